// File: doc/BRIEF.md
# Stream DMA Channel Control/Status Register Bank

This block is the register bank of one memory-to-stream DMA channel. Software reaches it through an AXI4-Lite slave port. It holds a control word and a status word. The control word sets run/stop, soft reset, fixed-address reads, the interrupt enables, a completion-count threshold and a delay timeout. The status word reports the halted and idle state, sticky error flags and three interrupt flags.

The datapath of the channel reports to the bank with a busy level and single-cycle pulses for transfer completion, slave error and decode error. The bank returns a run level, a flush request, the fixed-address mode and a single interrupt line. An error stops the channel in hardware. The halted flag waits until the engine reports that it is no longer busy. A soft reset stays in progress until the engine has drained, and then every register returns to its reset value.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x00010000, the status word (offset 0x04) reads 0x00000001, and run_o and irq_o are 0.
- R2: The control word stores run in bit 0, fixed-address mode in bit 3, the completion, delay and error interrupt enables in bits 12, 13 and 14, the threshold in bits 23:16 and the delay in bits 31:24. Reserved bits read 0. A write updates the word whatever the strobes are. Any address other than 0x00 and 0x04 reads 0.
- R3: The threshold resets to 1, and a write whose threshold field is 0 keeps the stored value. Status bit 12 sets on the completion that takes the count of completions since the last flag or threshold write up to the threshold.
- R4: Status bit 0 (halted) clears on the cycle after run is set. It sets only when run is 0 and the engine is not busy.
- R5: Status bit 1 (idle) reads 0 while halted. It sets on a completion pulse and clears while the engine is busy.
- R6: A slave error sets status bit 5 and a decode error sets status bit 6. Both bits are sticky. Either error clears run in hardware and sets status bit 14.
- R7: Writing 1 to status bits 12, 13 or 14 clears that bit. All other status bits ignore writes.
- R8: When the delay field D is nonzero, status bit 13 sets D×TICK_CLKS cycles after the last completion pulse, as long as no other completion arrives in between.
- R9: irq_o is high exactly when some status interrupt flag among bits 12, 13 and 14 is set together with its enable.
- R10: Writing 1 to control bit 2 clears run and raises flush_o. Bit 2 then reads 1 while the engine stays busy. Once the engine is not busy, every register returns to its reset value.
- R11: The fixed-address bit (control bit 3, keyhole_o) changes only when the write arrives while the channel is halted or idle. Otherwise the write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_busy_i | input | 1 | Engine has outstanding work |
| eng_done_i | input | 1 | One-cycle pulse for a completed transfer |
| eng_slv_err_i | input | 1 | One-cycle pulse for a slave error |
| eng_dec_err_i | input | 1 | One-cycle pulse for a decode error |
| run_o | output | 1 | Channel run level |
| flush_o | output | 1 | Soft reset in progress; engine must drain |
| keyhole_o | output | 1 | Fixed-address read mode |
| irq_o | output | 1 | Interrupt line |

## Verification
A wrong run, flush or interrupt state appears on run_o, flush_o or irq_o on the clock edge after its cause. These outputs are compared with a reference model on every cycle. Errors in the halted, idle, threshold count or delay timer state appear only in the status word. A wrong completion count shows as a flag that is early or late by one pulse. A wrong delay timer shows a set or clear bit 13 when the status word is read shortly after a completion or well after it. A soft reset that restores too early or too late shows in the control word read back while busy and again after the drain.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
   localparam int REG_W    = 32;
   localparam int THR_W    = 8;
   localparam int DLY_W    = 8;
   localparam int NIRQ     = 3;

   // control word bit positions
   localparam int C_RUN    = 0;
   localparam int C_SRST   = 2;
   localparam int C_FIXA   = 3;
   localparam int C_EN_LSB = 12;
   localparam int C_THR    = 16;
   localparam int C_DLY    = 24;

   // status word bit positions
   localparam int S_HALT   = 0;
   localparam int S_IDLE   = 1;
   localparam int S_SLV    = 5;
   localparam int S_DEC    = 6;
   localparam int S_FLG    = 12;

   // interrupt flag / enable index
   typedef enum int {IX_DONE = 0, IX_DLY = 1, IX_ERR = 2} irq_ix_e;

   localparam logic [THR_W-1:0] THR_RST = THR_W'(1);
endpackage

// File: rtl/dma_csr_axil.sv
module dma_csr_axil
   import dma_csr_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int CTRL_OFF = 0,
   parameter int STAT_OFF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [REG_W-1:0]  wdata,
   input  logic [REG_W/8-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [REG_W-1:0]  rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   output logic              wr_ctrl_o,
   output logic              wr_stat_o,
   output logic [REG_W-1:0]  wr_data_o,
   input  logic [REG_W-1:0]  ctrl_word_i,
   input  logic [REG_W-1:0]  stat_word_i
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFF);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFF);

   logic wr_go, rd_go;
   logic bvalid_q, rvalid_q;
   logic [REG_W-1:0] rdata_q;

   initial begin
      assert (CTRL_OFF != STAT_OFF && CTRL_OFF % 4 == 0 && STAT_OFF % 4 == 0)
         else $error("register offsets must be distinct and word aligned");
      assert (ADDR_W >= 3) else $error("ADDR_W too small for two words");
   end

   assign wr_go   = awvalid && wvalid && !bvalid_q;
   assign rd_go   = arvalid && !rvalid_q;
   assign awready = wr_go;
   assign wready  = wr_go;
   assign arready = rd_go;
   assign bvalid  = bvalid_q;
   assign rvalid  = rvalid_q;
   assign rdata   = rdata_q;
   assign bresp   = 2'b00;
   assign rresp   = 2'b00;

   assign wr_ctrl_o = wr_go && (awaddr == A_CTRL);
   assign wr_stat_o = wr_go && (awaddr == A_STAT);
   assign wr_data_o = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (wr_go)       bvalid_q <= 1'b1;
         else if (bready) bvalid_q <= 1'b0;
         if (rd_go) begin
            rvalid_q <= 1'b1;
            if (araddr == A_CTRL)      rdata_q <= ctrl_word_i;
            else if (araddr == A_STAT) rdata_q <= stat_word_i;
            else                       rdata_q <= '0;
         end else if (rready) begin
            rvalid_q <= 1'b0;
         end
      end
   end

   assert_bresp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> bvalid);
   assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !rready) |=> $stable(rdata));
   assert_strobe_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid |-> !$isunknown(wstrb));
endmodule

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
   import dma_csr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic              slv_err_i,
   input  logic              dec_err_i,
   output logic              clr_o,
   output logic              run_o,
   output logic              srst_o,
   output logic              fixa_o,
   output logic [NIRQ-1:0]   en_o,
   output logic [THR_W-1:0]  thr_o,
   output logic [DLY_W-1:0]  dly_o,
   output logic              halted_o,
   output logic              idle_o,
   output logic              slv_o,
   output logic              dec_o
);
   logic run_q, srst_q, fixa_q, halted_q, idle_q, slv_q, dec_q;
   logic [NIRQ-1:0]  en_q;
   logic [THR_W-1:0] thr_q;
   logic [DLY_W-1:0] dly_q;
   logic [THR_W-1:0] thr_new;
   logic quiet, any_err, clr;

   assign thr_new = wr_data_i[C_THR +: THR_W];
   assign quiet   = halted_q || idle_q;
   assign any_err = slv_err_i || dec_err_i;
   assign clr     = srst_q && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0; srst_q <= 1'b0; fixa_q <= 1'b0; en_q <= '0;
         thr_q <= THR_RST; dly_q <= '0;
         halted_q <= 1'b1; idle_q <= 1'b0; slv_q <= 1'b0; dec_q <= 1'b0;
      end else if (clr) begin
         run_q <= 1'b0; srst_q <= 1'b0; fixa_q <= 1'b0; en_q <= '0;
         thr_q <= THR_RST; dly_q <= '0;
         halted_q <= 1'b1; idle_q <= 1'b0; slv_q <= 1'b0; dec_q <= 1'b0;
      end else begin
         if (wr_ctrl_i) begin
            run_q <= wr_data_i[C_RUN] && !wr_data_i[C_SRST];
            if (wr_data_i[C_SRST]) srst_q <= 1'b1;
            if (quiet)             fixa_q <= wr_data_i[C_FIXA];
            en_q  <= wr_data_i[C_EN_LSB +: NIRQ];
            if (thr_new != '0)     thr_q <= thr_new;
            dly_q <= wr_data_i[C_DLY +: DLY_W];
         end
         if (any_err)   run_q <= 1'b0;
         if (slv_err_i) slv_q <= 1'b1;
         if (dec_err_i) dec_q <= 1'b1;

         if (run_q)        halted_q <= 1'b0;
         else if (!busy_i) halted_q <= 1'b1;

         if (halted_q)     idle_q <= 1'b0;
         else if (done_i)  idle_q <= 1'b1;
         else if (busy_i)  idle_q <= 1'b0;
      end
   end

   assign clr_o    = clr;
   assign run_o    = run_q;
   assign srst_o   = srst_q;
   assign fixa_o   = fixa_q;
   assign en_o     = en_q;
   assign thr_o    = thr_q;
   assign dly_o    = dly_q;
   assign halted_o = halted_q;
   assign idle_o   = idle_q && !halted_q;
   assign slv_o    = slv_q;
   assign dec_o    = dec_q;

   assert_err_stops_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      any_err |=> !run_q);
   assert_halt_after_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted_q) |-> ($past(!run_q) && $past(!busy_i)));
   assert_flush_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_q && busy_i) |=> srst_q);
   assert_thr_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      thr_q != '0);
   assert_fixa_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(fixa_q) |-> ($past(quiet) || $past(clr)));
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq
   import dma_csr_pkg::*;
#(
   parameter int TICK_CLKS = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              done_i,
   input  logic              err_i,
   input  logic              thr_load_i,
   input  logic [THR_W-1:0]  thr_new_i,
   input  logic [THR_W-1:0]  thr_i,
   input  logic [DLY_W-1:0]  dly_i,
   input  logic [NIRQ-1:0]   w1c_i,
   input  logic [NIRQ-1:0]   en_i,
   output logic [NIRQ-1:0]   flags_o,
   output logic              irq_o
);
   localparam int PRE_W = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;

   logic [THR_W-1:0] cnt_q;
   logic [DLY_W-1:0] tcnt_q;
   logic [NIRQ-1:0]  flg_q;
   logic armed_q, tick, hit, fire;

   initial begin
      assert (TICK_CLKS >= 1) else $error("TICK_CLKS must be at least 1");
   end

   generate
      if (TICK_CLKS == 1) begin : g_no_pre
         assign tick = armed_q;
      end else begin : g_pre
         logic [PRE_W-1:0] pre_q;
         assign tick = armed_q && (pre_q == PRE_W'(TICK_CLKS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      pre_q <= '0;
            else if (clr_i || done_i || !armed_q || tick) pre_q <= '0;
            else                             pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   assign hit  = done_i && (cnt_q <= THR_W'(1));
   assign fire = tick && (dly_i != '0) && (DLY_W'(tcnt_q + 1'b1) == dly_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= THR_RST; tcnt_q <= '0; armed_q <= 1'b0; flg_q <= '0;
      end else if (clr_i) begin
         cnt_q <= THR_RST; tcnt_q <= '0; armed_q <= 1'b0; flg_q <= '0;
      end else begin
         if (hit)                 flg_q[IX_DONE] <= 1'b1;
         else if (w1c_i[IX_DONE]) flg_q[IX_DONE] <= 1'b0;
         if (fire)                flg_q[IX_DLY] <= 1'b1;
         else if (w1c_i[IX_DLY])  flg_q[IX_DLY] <= 1'b0;
         if (err_i)               flg_q[IX_ERR] <= 1'b1;
         else if (w1c_i[IX_ERR])  flg_q[IX_ERR] <= 1'b0;

         if (thr_load_i)  cnt_q <= thr_new_i;
         else if (done_i) cnt_q <= hit ? thr_i : cnt_q - 1'b1;

         if (done_i) begin
            armed_q <= 1'b1;
            tcnt_q  <= '0;
         end else if (armed_q && dly_i == '0) begin
            armed_q <= 1'b0;
         end else if (tick) begin
            if (DLY_W'(tcnt_q + 1'b1) == dly_i) armed_q <= 1'b0;
            else                                tcnt_q  <= tcnt_q + 1'b1;
         end
      end
   end

   assign flags_o = flg_q;
   assign irq_o   = |(flg_q & en_i);

   assert_done_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_q[IX_DONE]) |-> $past(done_i));
   assert_dly_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_q[IX_DLY]) |-> ($past(armed_q) && $past(dly_i) != '0));
   assert_err_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_i && !clr_i) |=> flg_q[IX_ERR]);
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
   import dma_csr_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int CTRL_OFF  = 0,
   parameter int STAT_OFF  = 4,
   parameter int TICK_CLKS = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [31:0]       s_wdata,
   input  logic [3:0]        s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   input  logic              eng_busy_i,
   input  logic              eng_done_i,
   input  logic              eng_slv_err_i,
   input  logic              eng_dec_err_i,
   output logic              run_o,
   output logic              flush_o,
   output logic              keyhole_o,
   output logic              irq_o
);
   logic wr_ctrl, wr_stat, clr;
   logic [REG_W-1:0] wr_data, ctrl_word, stat_word;
   logic srst, fixa, halted, idle, slv, dec;
   logic [NIRQ-1:0]  en, flags, w1c;
   logic [THR_W-1:0] thr;
   logic [DLY_W-1:0] dly;
   logic thr_load;

   dma_csr_axil #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF), .STAT_OFF(STAT_OFF)) u_bus (
      .clk(clk), .rst_n(rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .wr_ctrl_o(wr_ctrl), .wr_stat_o(wr_stat), .wr_data_o(wr_data),
      .ctrl_word_i(ctrl_word), .stat_word_i(stat_word)
   );

   dma_csr_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_ctrl_i(wr_ctrl), .wr_data_i(wr_data),
      .busy_i(eng_busy_i), .done_i(eng_done_i),
      .slv_err_i(eng_slv_err_i), .dec_err_i(eng_dec_err_i),
      .clr_o(clr), .run_o(run_o), .srst_o(srst), .fixa_o(fixa), .en_o(en),
      .thr_o(thr), .dly_o(dly), .halted_o(halted), .idle_o(idle),
      .slv_o(slv), .dec_o(dec)
   );

   assign thr_load = wr_ctrl && (wr_data[C_THR +: THR_W] != '0);
   assign w1c      = wr_stat ? wr_data[S_FLG +: NIRQ] : '0;

   dma_csr_irq #(.TICK_CLKS(TICK_CLKS)) u_irq (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .done_i(eng_done_i),
      .err_i(eng_slv_err_i || eng_dec_err_i),
      .thr_load_i(thr_load), .thr_new_i(wr_data[C_THR +: THR_W]),
      .thr_i(thr), .dly_i(dly), .w1c_i(w1c), .en_i(en),
      .flags_o(flags), .irq_o(irq_o)
   );

   always_comb begin
      ctrl_word = '0;
      ctrl_word[C_RUN]              = run_o;
      ctrl_word[C_SRST]             = srst;
      ctrl_word[C_FIXA]             = fixa;
      ctrl_word[C_EN_LSB +: NIRQ]   = en;
      ctrl_word[C_THR +: THR_W]     = thr;
      ctrl_word[C_DLY +: DLY_W]     = dly;
      stat_word = '0;
      stat_word[S_HALT]             = halted;
      stat_word[S_IDLE]             = idle;
      stat_word[S_SLV]              = slv;
      stat_word[S_DEC]              = dec;
      stat_word[S_FLG +: NIRQ]      = flags;
   end

   assign flush_o   = srst;
   assign keyhole_o = fixa;

   assert_idle_not_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(halted && idle));
   assert_flush_stops_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> !run_o);
endmodule

// File: tb/tb_dma_csr_bank.sv
module tb_dma_csr_bank;
   localparam int TICK = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0] awaddr = '0, araddr = '0;
   logic awvalid = 0, wvalid = 0, arvalid = 0;
   logic [31:0] wdata = '0;
   logic [3:0] wstrb = 4'hF;
   logic awready, wready, bvalid, arready, rvalid;
   logic [1:0] bresp, rresp;
   logic [31:0] rdata;
   logic busy = 0, done = 0, slv = 0, dec = 0;
   logic run_o, flush_o, keyhole_o, irq_o;

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   dma_csr_bank #(.TICK_CLKS(TICK)) dut (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
      .eng_busy_i(busy), .eng_done_i(done),
      .eng_slv_err_i(slv), .eng_dec_err_i(dec),
      .run_o(run_o), .flush_o(flush_o), .keyhole_o(keyhole_o), .irq_o(irq_o)
   );

   // behavioural reference for the output levels
   bit m_rs, m_srst, m_kh, m_halt, m_idle, m_arm, m_bv;
   bit [2:0] m_en, m_f;
   int m_thr, m_dlyv, m_cnt, m_pre, m_tc;

   task automatic model_reset();
      m_rs = 0; m_srst = 0; m_kh = 0; m_en = 0; m_thr = 1; m_dlyv = 0;
      m_halt = 1; m_idle = 0; m_f = 0; m_cnt = 1; m_arm = 0; m_pre = 0; m_tc = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
         m_bv = 0;
      end else begin
         bit wr, wctl, clr, quiet, tick, hit, fire;
         int thrn;
         bit [31:0] wc;
         wr    = awvalid && wvalid && !m_bv;
         m_bv  = wr;
         wctl  = wr && awaddr == 6'h00;
         wc    = (wr && awaddr == 6'h04) ? wdata : 32'h0;
         thrn  = int'(wdata[23:16]);
         clr   = m_srst && !busy;
         quiet = m_halt || m_idle;
         tick  = m_arm && (m_pre == TICK - 1);
         if (clr) model_reset();
         else begin
            hit  = done && m_cnt <= 1;
            fire = tick && m_dlyv != 0 && ((m_tc + 1) % 256) == m_dlyv;
            if (hit) m_f[0] = 1; else if (wc[12]) m_f[0] = 0;
            if (fire) m_f[1] = 1; else if (wc[13]) m_f[1] = 0;
            if (slv || dec) m_f[2] = 1; else if (wc[14]) m_f[2] = 0;
            if (wctl && thrn != 0) m_cnt = thrn;
            else if (done) m_cnt = hit ? m_thr : m_cnt - 1;
            if (done || !m_arm || tick) m_pre = 0; else m_pre++;
            if (done) begin m_arm = 1; m_tc = 0; end
            else if (m_arm && m_dlyv == 0) m_arm = 0;
            else if (tick) begin
               if (((m_tc + 1) % 256) == m_dlyv) m_arm = 0; else m_tc++;
            end
            if (m_halt) m_idle = 0; else if (done) m_idle = 1; else if (busy) m_idle = 0;
            if (m_rs) m_halt = 0; else if (!busy) m_halt = 1;
            if (wctl) begin
               m_rs = wdata[0] && !wdata[2];
               if (wdata[2]) m_srst = 1;
               if (quiet) m_kh = wdata[3];
               m_en = wdata[14:12];
               if (thrn != 0) m_thr = thrn;
               m_dlyv = int'(wdata[31:24]);
            end
            if (slv || dec) m_rs = 0;
         end
      end
   end

   // per-cycle comparison of the output levels, away from the edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit m_irq;
         m_irq = |(m_f & m_en);
         checks++;
         if (run_o !== m_rs) begin
            fails++; $display("FAIL R6 run_o cycle %0d: got %0b exp %0b", cyc, run_o, m_rs);
         end
         checks++;
         if (irq_o !== m_irq) begin
            fails++; $display("FAIL R9 irq_o cycle %0d: got %0b exp %0b", cyc, irq_o, m_irq);
         end
         checks++;
         if (flush_o !== m_srst) begin
            fails++; $display("FAIL R10 flush_o cycle %0d: got %0b exp %0b", cyc, flush_o, m_srst);
         end
         checks++;
         if (keyhole_o !== m_kh) begin
            fails++; $display("FAIL R11 keyhole_o cycle %0d: got %0b exp %0b", cyc, keyhole_o, m_kh);
         end
      end
   end

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
      @(negedge clk);
      awvalid = 0; wvalid = 0;
      @(negedge clk);
   endtask

   task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      araddr = a; arvalid = 1;
      @(negedge clk);
      arvalid = 0;
      checks++;
      if (!rvalid || rdata !== exp) begin
         fails++;
         $display("FAIL %s read 0x%0h: got 0x%08h exp 0x%08h", req, a, rdata, exp);
      end
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1;
      @(negedge clk); sig = 0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout exp completion");
         finish_run();
      end
   end

   initial begin
      idle_cycles(4);
      rst_n = 1;
      // R1 reset state
      rd_chk(6'h00, 32'h0001_0000, "R1");
      rd_chk(6'h04, 32'h0000_0001, "R1");
      // R2 unmapped address, reserved bits, strobes ignored
      rd_chk(6'h08, 32'h0, "R2");
      wr_reg(6'h00, 32'h0000_8FF2, 4'h0);
      rd_chk(6'h00, 32'h0001_0000, "R2");
      wr_reg(6'h00, 32'h0003_7001, 4'h1);
      rd_chk(6'h00, 32'h0003_7001, "R2");
      // R4 halted clears after run
      rd_chk(6'h04, 32'h0000_0000, "R4");
      // R3 zero threshold write keeps 3
      wr_reg(6'h00, 32'h0000_7001, 4'hF);
      rd_chk(6'h00, 32'h0003_7001, "R3");
      // R3 / R5 completion counting and idle
      pulse(done);
      pulse(done);
      rd_chk(6'h04, 32'h0000_0002, "R3 R5");
      pulse(done);
      rd_chk(6'h04, 32'h0000_1002, "R3");
      // R7 write-one-to-clear; read-only bits unaffected
      wr_reg(6'h04, 32'h0000_1063, 4'hF);
      rd_chk(6'h04, 32'h0000_0002, "R7");
      // R5 idle clears while busy
      @(negedge clk); busy = 1;
      rd_chk(6'h04, 32'h0000_0000, "R5");
      @(negedge clk); busy = 0;
      // R8 delay timer, D=2, 8 cycles after completion
      wr_reg(6'h00, 32'h0203_7001, 4'hF);
      pulse(done);
      rd_chk(6'h04, 32'h0000_0002, "R8");
      idle_cycles(10);
      rd_chk(6'h04, 32'h0000_2002, "R8");
      wr_reg(6'h04, 32'h0000_2000, 4'hF);
      rd_chk(6'h04, 32'h0000_0002, "R7");
      // R11 fixed-address bit ignored while busy and running
      @(negedge clk); busy = 1;
      wr_reg(6'h00, 32'h0203_7009, 4'hF);
      rd_chk(6'h00, 32'h0203_7001, "R11");
      // R6 slave error stops run, halt waits for drain
      pulse(slv);
      rd_chk(6'h04, 32'h0000_4020, "R6");
      @(negedge clk); busy = 0;
      idle_cycles(2);
      rd_chk(6'h04, 32'h0000_4021, "R4 R6");
      // R11 fixed-address bit accepted while halted
      wr_reg(6'h00, 32'h0203_7008, 4'hF);
      rd_chk(6'h00, 32'h0203_7008, "R11");
      // R7 / R6 error flag clears, sticky error bits stay
      wr_reg(6'h04, 32'h0000_4060, 4'hF);
      rd_chk(6'h04, 32'h0000_0021, "R7 R6");
      pulse(dec);
      rd_chk(6'h04, 32'h0000_4061, "R6");
      // R10 soft reset held while busy, then restores
      @(negedge clk); busy = 1;
      wr_reg(6'h00, 32'h0000_0004, 4'hF);
      rd_chk(6'h00, 32'h0003_0004, "R10");
      idle_cycles(3);
      rd_chk(6'h00, 32'h0003_0004, "R10");
      @(negedge clk); busy = 0;
      idle_cycles(2);
      rd_chk(6'h00, 32'h0001_0000, "R10");
      rd_chk(6'h04, 32'h0000_0001, "R10");
      // R3 threshold back to 1 after soft reset
      wr_reg(6'h00, 32'h0000_1001, 4'hF);
      pulse(done);
      rd_chk(6'h04, 32'h0000_1002, "R3");
      idle_cycles(2);
      finish_run();
   end
endmodule